// File: doc/BRIEF.md
# Interval-Timed Multi-Sensor Measurement Sequencer

This block decides when an external converter samples each of up to four temperature sensing points. A prescaler turns a programmable period-unit value into a slow time base, and every delay the block inserts is a whole number of those base ticks. In each round the sequencer visits the enabled sensing points in ascending index order. It takes the programmed number of samples from each one, and after the last enabled point it pauses before the next round begins.

There are three kinds of pause: one between two samples of the same point, one when moving on to the next point, and one between rounds. The sequencer raises a one-cycle start pulse with the sensor index beside it. It then waits for the converter's completion strobe before the next pause begins counting. The enable map is sampled only when a round starts, so a map written mid-round shapes the following round.

Top module: `msq_sequencer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `adc_start` is low and the sequencer is idle.
- R2: One base tick lasts `unit` × 2^TICK_SHIFT clock cycles (TICK_SHIFT defaults to 8, giving 256). A `unit` of 0 behaves as 1. A pause of N ticks therefore separates a completion strobe from the next start pulse by exactly 1 + N × tick cycles.
- R3: Within a round, starts go to enabled points in ascending index order, and points whose enable bit is 0 are skipped. Point i takes n samples, where n is the field `smp_cfg[i*SMP_W +: SMP_W]`; a field of 0 counts as one sample.
- R4: Between two samples of the same point the pause is `filt_gap` ticks.
- R5: After the last sample of one point, the first sample of the next enabled point follows after `sens_gap` ticks.
- R6: After the last sample of the highest enabled point, `round_gap` ticks pass. The next round then starts at the lowest point enabled at that moment.
- R7: A pause value of 0 puts the next start pulse on the clock cycle right after the completion strobe.
- R8: After a start pulse no pause begins until `adc_done` is seen. A completion strobe that arrives while the sequencer is not waiting for one has no effect on the timing.
- R9: With an all-zero enable map the sequencer idles and issues no start pulses. A nonzero map written while idle starts a round one cycle after it is sampled.
- R10: The enable map is captured only when a round starts. Changes made during a round do not alter which points that round visits.
- R11: `adc_start` is high for exactly one cycle per sample, and `adc_sel` carries the index of the point being sampled during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sens_en | input | NUM_SENS | Enable map, bit i enables sensing point i |
| unit | input | PU_W | Period unit; tick = unit × 2^TICK_SHIFT cycles |
| filt_gap | input | IV_W | Ticks between samples of one point |
| sens_gap | input | IV_W | Ticks between the last sample of one point and the next point |
| round_gap | input | IV_W | Ticks between rounds |
| smp_cfg | input | NUM_SENS×SMP_W | Per-point sample counts, point i at bits i*SMP_W upward |
| adc_done | input | 1 | Completion strobe from the converter |
| adc_start | output | 1 | One-cycle conversion start pulse |
| adc_sel | output | IDX_W | Index of the point being sampled |

## Verification
The bench builds the block with TICK_SHIFT = 2, so one tick is 4 × `unit` cycles instead of 256 × `unit`. This makes pauses of several ticks and whole rounds short enough to run many rounds. Period units of 1 and 3 are both exercised, along with sample counts of 0, 1, 2 and 3, sparse and full enable maps, all-zero pauses, map rewrites in the middle of a round, and stray completion strobes during pauses. A behavioural model predicts the exact cycle and index of every start pulse from these settings.

// File: rtl/msq_pkg.sv
package msq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FIRE = 2'd1,
    ST_HOLD = 2'd2,
    ST_GAP  = 2'd3
  } msq_state_e;
endpackage

// File: rtl/msq_tick_gen.sv
module msq_tick_gen #(
  parameter int PU_W       = 10,
  parameter int TICK_SHIFT = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PU_W-1:0] unit,
  output logic            tick
);
  localparam int CW = PU_W + TICK_SHIFT;

  logic [CW-1:0]   cnt_q, cnt_d, limit;
  logic [PU_W-1:0] unit_eff;

  always_comb begin
    unit_eff = (unit == '0) ? PU_W'(1) : unit;
    limit    = (CW'(unit_eff) << TICK_SHIFT) - CW'(1);
    tick     = run && (cnt_q >= limit);
  end

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && limit != '0) |=> (cnt_q == '0));

endmodule

// File: rtl/msq_gap_cnt.sv
module msq_gap_cnt #(
  parameter int IV_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [IV_W-1:0] load_val,
  input  logic            tick,
  output logic            busy,
  output logic            expire
);
  logic [IV_W-1:0] rem_q, rem_d;

  always_comb begin
    busy   = (rem_q != '0);
    expire = tick && (rem_q == IV_W'(1));
    if (load)              rem_d = load_val;
    else if (tick && busy) rem_d = rem_q - IV_W'(1);
    else                   rem_d = rem_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end

  // R4 R5 R6
  load_vs_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !expire);

endmodule

// File: rtl/msq_pick.sv
module msq_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/msq_sequencer.sv
module msq_sequencer
  import msq_pkg::*;
#(
  parameter int NUM_SENS   = 4,
  parameter int PU_W       = 10,
  parameter int IV_W       = 10,
  parameter int SMP_W      = 3,
  parameter int TICK_SHIFT = 8,
  localparam int IDX_W     = (NUM_SENS > 1) ? $clog2(NUM_SENS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SENS-1:0]       sens_en,
  input  logic [PU_W-1:0]           unit,
  input  logic [IV_W-1:0]           filt_gap,
  input  logic [IV_W-1:0]           sens_gap,
  input  logic [IV_W-1:0]           round_gap,
  input  logic [NUM_SENS*SMP_W-1:0] smp_cfg,
  input  logic                      adc_done,
  output logic                      adc_start,
  output logic [IDX_W-1:0]          adc_sel
);
  msq_state_e          state_q, state_d;
  logic [IDX_W-1:0]    cur_q, cur_d, pend_sens_q, pend_sens_d;
  logic [SMP_W-1:0]    smp_q, smp_d, pend_smp_q, pend_smp_d;
  logic                pend_grp_q, pend_grp_d;
  logic [NUM_SENS-1:0] map_q, map_d, above;

  logic             next_found, new_found, tick, gap_busy, gap_expire, gap_load;
  logic [IDX_W-1:0] next_idx, new_idx;

  // points of the captured map that lie above the current one
  for (genvar g = 0; g < NUM_SENS; g++) begin : g_above
    assign above[g] = (g > int'(cur_q));
  end

  msq_pick #(.N(NUM_SENS), .IDX_W(IDX_W)) u_pick_next (
    .req(map_q & above), .found(next_found), .idx(next_idx));

  msq_pick #(.N(NUM_SENS), .IDX_W(IDX_W)) u_pick_new (
    .req(sens_en), .found(new_found), .idx(new_idx));

  // sample-count decision for the current point
  logic [SMP_W-1:0] cfg_n, eff_n;
  logic             more;
  always_comb begin
    cfg_n = smp_cfg[cur_q*SMP_W +: SMP_W];
    eff_n = (cfg_n == '0) ? SMP_W'(1) : cfg_n;
    more  = ({1'b0, smp_q} + (SMP_W+1)'(1)) < {1'b0, eff_n};
  end

  // candidate for the next sample once the converter reports done
  logic [IDX_W-1:0] c_sens;
  logic [SMP_W-1:0] c_smp;
  logic             c_grp;
  logic [IV_W-1:0]  c_gap;
  always_comb begin
    if (more) begin
      c_sens = cur_q;    c_smp = smp_q + SMP_W'(1); c_grp = 1'b0; c_gap = filt_gap;
    end else if (next_found) begin
      c_sens = next_idx; c_smp = '0;                c_grp = 1'b0; c_gap = sens_gap;
    end else begin
      c_sens = cur_q;    c_smp = '0;                c_grp = 1'b1; c_gap = round_gap;
    end
  end

  logic             in_hold_done, go_now, d_grp;
  logic [IDX_W-1:0] d_sens;
  logic [SMP_W-1:0] d_smp;
  always_comb begin
    in_hold_done = (state_q == ST_HOLD) && adc_done;
    gap_load     = in_hold_done && (c_gap != '0);
    go_now       = (in_hold_done && (c_gap == '0)) ||
                   ((state_q == ST_GAP) && gap_expire);
    d_grp        = (state_q == ST_HOLD) ? c_grp  : pend_grp_q;
    d_sens       = (state_q == ST_HOLD) ? c_sens : pend_sens_q;
    d_smp        = (state_q == ST_HOLD) ? c_smp  : pend_smp_q;
  end

  msq_tick_gen #(.PU_W(PU_W), .TICK_SHIFT(TICK_SHIFT)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_GAP), .unit(unit), .tick(tick));

  msq_gap_cnt #(.IV_W(IV_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(c_gap),
    .tick(tick), .busy(gap_busy), .expire(gap_expire));

  // next-state logic
  always_comb begin
    state_d     = state_q;
    cur_d       = cur_q;
    smp_d       = smp_q;
    map_d       = map_q;
    pend_sens_d = pend_sens_q;
    pend_smp_d  = pend_smp_q;
    pend_grp_d  = pend_grp_q;
    unique case (state_q)
      ST_IDLE: begin
        map_d = sens_en;
        if (new_found) begin
          state_d = ST_FIRE;
          cur_d   = new_idx;
          smp_d   = '0;
        end
      end
      ST_FIRE: state_d = ST_HOLD;
      ST_HOLD: begin
        if (adc_done) begin
          pend_sens_d = c_sens;
          pend_smp_d  = c_smp;
          pend_grp_d  = c_grp;
          if (c_gap != '0) state_d = ST_GAP;
        end
      end
      ST_GAP: ;
      default: state_d = ST_IDLE;
    endcase
    if (go_now) begin
      if (d_grp) begin
        map_d = sens_en;
        if (new_found) begin
          state_d = ST_FIRE;
          cur_d   = new_idx;
          smp_d   = '0;
        end else begin
          state_d = ST_IDLE;
        end
      end else begin
        state_d = ST_FIRE;
        cur_d   = d_sens;
        smp_d   = d_smp;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cur_q       <= '0;
      smp_q       <= '0;
      map_q       <= '0;
      pend_sens_q <= '0;
      pend_smp_q  <= '0;
      pend_grp_q  <= 1'b0;
    end else begin
      state_q     <= state_d;
      cur_q       <= cur_d;
      smp_q       <= smp_d;
      map_q       <= map_d;
      pend_sens_q <= pend_sens_d;
      pend_smp_q  <= pend_smp_d;
      pend_grp_q  <= pend_grp_d;
    end
  end

  assign adc_start = (state_q == ST_FIRE);
  assign adc_sel   = cur_q;

  // R11
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  // R3
  start_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> map_q[adc_sel]);

  // R8
  wait_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && !adc_done) |=> (state_q == ST_HOLD));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && sens_en == '0) |=> !adc_start);

  // R10
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIRE) |=> $stable(map_q));

  // R4 R5 R6
  gap_counting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GAP) |-> gap_busy);

endmodule

// File: tb/test_msq_sequencer.sv
`timescale 1ns/1ps
module test_msq_sequencer;
  localparam int TS = 2;
  localparam int WD = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  sens_en;
  logic [9:0]  unit, filt_gap, sens_gap, round_gap;
  logic [11:0] smp_cfg;
  logic        adc_done = 1'b0;
  logic        adc_start;
  logic [1:0]  adc_sel;

  msq_sequencer #(.TICK_SHIFT(TS)) i_msq_sequencer (
    .clk(clk), .rst_n(rst_n), .sens_en(sens_en), .unit(unit),
    .filt_gap(filt_gap), .sens_gap(sens_gap), .round_gap(round_gap),
    .smp_cfg(smp_cfg), .adc_done(adc_done), .adc_start(adc_start),
    .adc_sel(adc_sel));

  always #2.5 clk = ~clk;

  int    checks = 0, failures = 0, cyc = 0, nstart = 0, phase_starts = 0;
  bit    finished = 0, spur_en = 0;
  bit    m_idle = 1, wait_done = 0;
  int    idle_from = 0, exp_start = -1, grp_cyc = -1, resp_cyc = -1;
  int    m_cur = 0, m_smp = 0, exp_sel = 0;
  logic [3:0] m_map = '0;
  string exp_tag = "R9";

  function automatic int tick_len();
    return ((unit == 0) ? 1 : int'(unit)) << TS;
  endfunction

  function automatic int n_of(int s);
    int v = int'((smp_cfg >> (s * 3)) & 12'h7);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic fail_msg(string tag, string what, int act, int exp);
    failures++;
    $display("FAIL %s: %s actual=%0d expected=%0d cycle=%0d", tag, what, act, exp, cyc);
  endtask

  task automatic start_round(int c, string tag);
    m_map = sens_en;
    m_idle = 0;
    for (int s = 3; s >= 0; s--) if (m_map[s]) m_cur = s;
    m_smp = 0;
    exp_start = c + 1;
    exp_sel = m_cur;
    exp_tag = tag;
  endtask

  task automatic decide(int c);
    int nxt = -1;
    if (m_smp + 1 < n_of(m_cur)) begin
      m_smp++;
      exp_start = c + 1 + int'(filt_gap) * tick_len();
      exp_sel = m_cur;
      exp_tag = (filt_gap == 0) ? "R7 R4" : "R4 R2";
    end else begin
      for (int s = 3; s > m_cur; s--) if (m_map[s]) nxt = s;
      if (nxt >= 0) begin
        m_cur = nxt;
        m_smp = 0;
        exp_start = c + 1 + int'(sens_gap) * tick_len();
        exp_sel = m_cur;
        exp_tag = (sens_gap == 0) ? "R7 R5 R10" : "R5 R3 R10";
      end else begin
        grp_cyc = c + int'(round_gap) * tick_len();
      end
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // reference model, compare and converter responder
  always @(negedge clk) begin
    cyc++;
    if (cyc > WD && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, WD);
      summary();
      $finish;
    end
    if (!rst_n) begin
      checks++;
      if (adc_start !== 1'b0) fail_msg("R1", "adc_start in reset", int'(adc_start), 0);
      m_idle = 1; idle_from = 0; exp_start = -1; grp_cyc = -1;
      wait_done = 0; adc_done = 1'b0;
    end else begin
      checks++;
      if (adc_start !== (cyc == exp_start)) begin
        if (adc_start === 1'b1)
          fail_msg(m_idle ? "R9" : "R8", "unexpected adc_start", 1, 0);
        else
          fail_msg(exp_tag, "missing adc_start", int'(adc_start), 1);
      end else if (adc_start) begin
        checks++;
        if (adc_sel !== 2'(exp_sel)) fail_msg("R11", "adc_sel", int'(adc_sel), exp_sel);
        wait_done = 1;
        resp_cyc = cyc + 1 + (nstart % 4);
        nstart++;
        phase_starts++;
        exp_start = -1;
      end
      if (wait_done && cyc == resp_cyc) begin
        adc_done = 1'b1;
        wait_done = 0;
        decide(cyc);
      end else begin
        adc_done = (spur_en && !wait_done && (cyc % 5 == 2));
      end
      if (cyc == grp_cyc) begin
        grp_cyc = -1;
        if (sens_en == 4'b0) begin
          m_map = '0; m_idle = 1; idle_from = cyc + 1;
        end else start_round(cyc, "R6 R10");
      end
      if (m_idle && cyc >= idle_from && sens_en != 4'b0) start_round(cyc, "R9 R3");
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic need_starts(int minimum, string tag);
    checks++;
    if (phase_starts < minimum) fail_msg(tag, "start pulses in phase", phase_starts, minimum);
    phase_starts = 0;
  endtask

  task automatic need_none(string tag);
    checks++;
    if (phase_starts != 0) fail_msg(tag, "start pulses while idle", phase_starts, 0);
    phase_starts = 0;
  endtask

  task automatic go_idle();
    sens_en = 4'b0;
    for (int k = 0; k < 800 && !m_idle; k++) step(1);
    checks++;
    if (!m_idle) fail_msg("R9", "model reached idle", 0, 1);
    step(20);
    phase_starts = 0;
    step(40);
    need_none("R9");
  endtask

  initial begin
    rst_n = 1'b0;
    sens_en = 4'b0;
    unit = 10'd1;
    filt_gap = 10'd2; sens_gap = 10'd1; round_gap = 10'd3;
    smp_cfg = {3'd3, 3'd0, 3'd1, 3'd2};
    step(5);
    rst_n = 1'b1;
    // R1 R9: quiet after reset with an empty map
    step(40);
    need_none("R1");
    // R3 R4 R5 R6: sparse map, mixed sample counts
    sens_en = 4'b1011;
    step(400);
    need_starts(10, "R3");
    // R7: all pauses zero
    filt_gap = 10'd0; sens_gap = 10'd0; round_gap = 10'd0;
    step(200);
    need_starts(20, "R7");
    // R10: map rewritten mid-round, then again
    filt_gap = 10'd1; sens_gap = 10'd2; round_gap = 10'd2;
    step(7);
    sens_en = 4'b0110;
    step(9);
    sens_en = 4'b1001;
    step(150);
    need_starts(5, "R10");
    // R8: stray completion strobes during pauses
    spur_en = 1;
    sens_en = 4'b0111;
    step(300);
    need_starts(8, "R8");
    spur_en = 0;
    // R9: back to idle, then change the period unit
    go_idle();
    unit = 10'd3;
    smp_cfg = {3'd1, 3'd2, 3'd0, 3'd1};
    sens_en = 4'b1111;
    step(600);
    need_starts(6, "R2");
    // R3: single high point with a zero sample field
    sens_en = 4'b1000;
    smp_cfg = {3'd0, 3'd2, 3'd2, 3'd2};
    step(300);
    need_starts(3, "R3");
    go_idle();
    // R11: every start carried a checked index
    checks++;
    if (nstart < 40) fail_msg("R11", "total start pulses", nstart, 40);
    finished = 1;
    summary();
    $finish;
  end
endmodule